// File: doc/BRIEF.md
# Integer Min/Max Execution Unit

This unit executes four two-operand selection operations on 64-bit integers: signed maximum, unsigned maximum, signed minimum and unsigned minimum. It receives a 32-bit instruction word together with the two source operand values, which have already been read from the register file. It decodes the instruction to pick the operation. One clock edge later it presents the selected value, the destination register index and, for the record form, a 4-bit condition field to write back.

Both minimum and maximum favour the second operand. The first operand is chosen only when the comparison holds strictly. The condition field always classifies the result as a signed number, even for the unsigned operations. Its lowest bit carries a summary-overflow flag supplied as a plain input. An instruction word the unit does not recognise raises an illegal-instruction pulse instead of a result.

Top module: `mm_unit`

## Requirements
- R1: An instruction is accepted only when its 6 most significant bits (instr[31:26]) equal 22. Otherwise `illegal` pulses and `out_valid` stays low.
- R2: For an accepted instruction, `dest_idx` equals instr[25:21]. The source index fields instr[20:16] and instr[15:11] have no effect on any output.
- R3: The operation is selected by the 10-bit field instr[10:1]: 0b0111001110 is signed max, 0b0011001110 is unsigned max, 0b0101001110 is signed min and 0b0001001110 is unsigned min. Any other value is illegal.
- R4: Signed max returns `opa` only when opa > opb as two's-complement values. Otherwise it returns `opb`.
- R5: Unsigned max returns `opa` only when opa > opb as unsigned values. Otherwise it returns `opb`.
- R6: Signed min returns `opa` only when opa < opb as two's-complement values. Otherwise it returns `opb`.
- R7: Unsigned min returns `opa` only when opa < opb as unsigned values. Otherwise it returns `opb`. For example, the unsigned min of 1 and 0x8000_0000_0000_0000 is 1.
- R8: For a record-form instruction (instr[0]=1), `cond_field[3:1]` reads the result as signed: 3'b100 when it is negative, 3'b010 when it is positive and 3'b001 when it is zero. This holds for the unsigned operations too.
- R9: For a record-form instruction, `cond_field[0]` equals the `so_in` value sampled with that instruction.
- R10: When instr[0]=0, `cond_we` stays low and `cond_field` keeps its previous value.
- R11: An illegal instruction pulses `illegal` for one cycle, keeps `out_valid` and `cond_we` low, and leaves `result`, `dest_idx` and `cond_field` unchanged.
- R12: Outputs appear on the clock edge that samples `in_valid`, so they are visible one cycle after issue. Synchronous reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| opa | input | 64 | First source operand value |
| opb | input | 64 | Second source operand value |
| so_in | input | 1 | Summary-overflow flag copied into the condition field |
| out_valid | output | 1 | Result and destination index are valid |
| result | output | 64 | Selected value |
| dest_idx | output | 5 | Destination register index |
| cond_we | output | 1 | Condition field write strobe |
| cond_field | output | 4 | Condition field: negative, positive, zero, summary overflow |
| illegal | output | 1 | Unrecognised instruction pulse |

## Verification
A wrong comparison sense or signedness shows up on the next cycle's `result`. It shows only for operand pairs whose sign bits differ or whose order matters, so the stimulus mixes random values with crafted sign-boundary pairs. A faulty condition classification or a stuck held value appears on `cond_field` in the cycle after a record-form instruction. A non-record instruction that overwrites the field, or an illegal one that overwrites `result`, is caught when the bench compares the held values in the following cycle.

// File: rtl/mm_pkg.sv
package mm_pkg;
    localparam int XLEN      = 64;
    localparam int ILEN      = 32;
    localparam int IDXW      = 5;
    localparam int CFW       = 4;
    localparam int POW       = 6;
    localparam int XOW       = 10;

    localparam logic [POW-1:0] PRIMARY_OP = 6'd22;
    localparam logic [XOW-1:0] XO_MAXS    = 10'b0111001110;
    localparam logic [XOW-1:0] XO_MAXU    = 10'b0011001110;
    localparam logic [XOW-1:0] XO_MINS    = 10'b0101001110;
    localparam logic [XOW-1:0] XO_MINU    = 10'b0001001110;

    typedef enum logic [1:0] {
        SEL_MAXS = 2'd0,
        SEL_MAXU = 2'd1,
        SEL_MINS = 2'd2,
        SEL_MINU = 2'd3
    } sel_op_e;

    typedef struct packed {
        logic            legal;
        sel_op_e         op;
        logic            rec;
        logic [IDXW-1:0] rt;
    } dec_t;

    function automatic logic op_is_max(sel_op_e op);
        return (op == SEL_MAXS) || (op == SEL_MAXU);
    endfunction

    function automatic logic op_is_signed(sel_op_e op);
        return (op == SEL_MAXS) || (op == SEL_MINS);
    endfunction
endpackage

// File: rtl/mm_decode.sv
module mm_decode
    import mm_pkg::*;
(
    input  logic [ILEN-1:0] instr,
    output dec_t            dec
);
    logic [POW-1:0] prim;
    logic [XOW-1:0] xo;
    logic           xo_hit;
    sel_op_e        op_sel;
    logic           unused_src_fields;

    assign prim = instr[ILEN-1 -: POW];
    assign xo   = instr[XOW:1];
    assign unused_src_fields = ^instr[20:11];

    always_comb begin
        xo_hit = 1'b1;
        op_sel = SEL_MAXS;
        unique case (xo)
            XO_MAXS: op_sel = SEL_MAXS;
            XO_MAXU: op_sel = SEL_MAXU;
            XO_MINS: op_sel = SEL_MINS;
            XO_MINU: op_sel = SEL_MINU;
            default: xo_hit = 1'b0;
        endcase
    end

    always_comb begin
        dec.legal = (prim == PRIMARY_OP) && xo_hit;
        dec.op    = op_sel;
        dec.rec   = instr[0];
        dec.rt    = instr[25:21];
    end
endmodule

// File: rtl/mm_select.sv
module mm_select
    import mm_pkg::*;
#(
    parameter int W = XLEN
) (
    input  sel_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [W-1:0] a_k, b_k;
    logic         a_gt, a_lt, pick_a;

    // Flipping the sign bits turns a two's-complement order into an unsigned one.
    assign a_k = op_is_signed(op) ? {~a[W-1], a[W-2:0]} : a;
    assign b_k = op_is_signed(op) ? {~b[W-1], b[W-2:0]} : b;

    assign a_gt   = a_k > b_k;
    assign a_lt   = a_k < b_k;
    assign pick_a = op_is_max(op) ? a_gt : a_lt;
    assign y      = pick_a ? a : b;
endmodule

// File: rtl/mm_cond.sv
module mm_cond
    import mm_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0]   value,
    input  logic           so,
    output logic [CFW-1:0] cf
);
    logic neg, zero;
    assign neg  = value[W-1];
    assign zero = (value == '0);
    assign cf   = {neg, ~neg & ~zero, zero, so};
endmodule

// File: rtl/mm_unit.sv
module mm_unit
    import mm_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [ILEN-1:0] instr,
    input  logic [W-1:0]    opa,
    input  logic [W-1:0]    opb,
    input  logic            so_in,
    output logic            out_valid,
    output logic [W-1:0]    result,
    output logic [IDXW-1:0] dest_idx,
    output logic            cond_we,
    output logic [CFW-1:0]  cond_field,
    output logic            illegal
);
    dec_t           dec;
    logic [W-1:0]   sel_y;
    logic [CFW-1:0] cf_next;
    logic           take, take_cf;

    mm_decode u_dec (.instr(instr), .dec(dec));

    mm_select #(.W(W)) u_sel (.op(dec.op), .a(opa), .b(opb), .y(sel_y));

    mm_cond #(.W(W)) u_cf (.value(sel_y), .so(so_in), .cf(cf_next));

    assign take    = in_valid & dec.legal;
    assign take_cf = take & dec.rec;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            illegal    <= 1'b0;
            cond_we    <= 1'b0;
            result     <= '0;
            dest_idx   <= '0;
            cond_field <= '0;
        end else begin
            out_valid <= take;
            illegal   <= in_valid & ~dec.legal;
            cond_we   <= take_cf;
            if (take) begin
                result   <= sel_y;
                dest_idx <= dec.rt;
            end
            if (take_cf) begin
                cond_field <= cf_next;
            end
        end
    end
endmodule

// File: rtl/mm_unit_chk.sv
module mm_unit_chk
    import mm_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [ILEN-1:0] instr,
    input logic [XLEN-1:0] opa,
    input logic [XLEN-1:0] opb,
    input logic            so_in,
    input logic            out_valid,
    input logic [XLEN-1:0] result,
    input logic [IDXW-1:0] dest_idx,
    input logic            cond_we,
    input logic [CFW-1:0]  cond_field,
    input logic            illegal
);
    assert_primary_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(instr[31:26]) == 6'd22));

    assert_dest_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (dest_idx == $past(instr[25:21])));

    assert_operand_pick_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((result == $past(opa)) || (result == $past(opb))));

    assert_cond_class_R8: assert property (@(posedge clk) disable iff (rst)
        cond_we |-> (($countones(cond_field[3:1]) == 1) && (cond_field[3] == result[XLEN-1])));

    assert_so_copy_R9: assert property (@(posedge clk) disable iff (rst)
        cond_we |-> (cond_field[0] == $past(so_in)));

    assert_cond_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !cond_we |-> $stable(cond_field));

    assert_illegal_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!out_valid && !cond_we && $stable(result)));

    assert_latency_R12: assert property (@(posedge clk) disable iff (rst)
        (out_valid || illegal) |-> $past(in_valid));
endmodule

bind mm_unit mm_unit_chk chk (.*);

// File: tb/mm_unit_test.sv
`timescale 1ns/1ps
module mm_unit_test;
    import mm_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] instr;
    logic [63:0] opa, opb;
    logic        so_in;
    logic        out_valid, cond_we, illegal;
    logic [63:0] result;
    logic [4:0]  dest_idx;
    logic [3:0]  cond_field;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [63:0] exp_res = '0;
    logic [4:0]  exp_dst = '0;
    logic [3:0]  exp_cf  = '0;

    always #2.5 clk = ~clk;

    mm_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .opa(opa), .opb(opb), .so_in(so_in), .out_valid(out_valid),
        .result(result), .dest_idx(dest_idx), .cond_we(cond_we),
        .cond_field(cond_field), .illegal(illegal)
    );

    function automatic logic [31:0] mk(logic [5:0] po, logic [9:0] xo,
                                       logic [4:0] rt, logic [4:0] ra,
                                       logic [4:0] rb, logic rc);
        return {po, rt, ra, rb, xo, rc};
    endfunction

    function automatic logic [63:0] model(logic [9:0] xo, logic [63:0] a, logic [63:0] b);
        case (xo)
            10'b0111001110: return ($signed(a) > $signed(b)) ? a : b;
            10'b0011001110: return (a > b) ? a : b;
            10'b0101001110: return ($signed(a) < $signed(b)) ? a : b;
            default:        return (a < b) ? a : b;
        endcase
    endfunction

    function automatic logic [3:0] cf_model(logic [63:0] r, logic so);
        if ($signed(r) < 0) return {3'b100, so};
        if (r == 0)         return {3'b001, so};
        return {3'b010, so};
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(logic [31:0] ins, logic [63:0] a, logic [63:0] b, logic so, string tag);
        logic [5:0] po;
        logic [9:0] xo;
        logic       ok;
        po = ins[31:26];
        xo = ins[10:1];
        ok = (po == 6'd22) && (xo == 10'b0111001110 || xo == 10'b0011001110 ||
                               xo == 10'b0101001110 || xo == 10'b0001001110);
        @(negedge clk);
        in_valid = 1'b1; instr = ins; opa = a; opb = b; so_in = so;
        @(negedge clk);
        in_valid = 1'b0;
        instr = $urandom; opa = $urandom; opb = $urandom; so_in = $urandom;
        if (ok) begin
            exp_res = model(xo, a, b);
            exp_dst = ins[25:21];
            if (ins[0]) exp_cf = cf_model(exp_res, so);
        end
        check({tag, " R1/R11 out_valid"}, 64'(out_valid), 64'(ok));
        check({tag, " R11 illegal"}, 64'(illegal), 64'(!ok));
        check({tag, " R10 cond_we"}, 64'(cond_we), 64'(ok && ins[0]));
        check({tag, " R4-model result"}, result, exp_res);
        check({tag, " R2 dest_idx"}, 64'(dest_idx), 64'(exp_dst));
        check({tag, " R8/R9 cond_field"}, 64'(cond_field), 64'(exp_cf));
    endtask

    localparam logic [9:0] X_MAXS = 10'b0111001110;
    localparam logic [9:0] X_MAXU = 10'b0011001110;
    localparam logic [9:0] X_MINS = 10'b0101001110;
    localparam logic [9:0] X_MINU = 10'b0001001110;

    initial begin
        #(5ns * 150000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] va = 64'hc523e996a8ff6215;
        logic [63:0] vb = 64'he1e5b9cc9864c4a8;
        logic [63:0] mn = 64'h8000_0000_0000_0000;
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; instr = '0; opa = '0; opb = '0; so_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check("R12 reset out_valid", 64'(out_valid), 0);
        check("R12 reset result", result, 0);
        check("R12 reset cond_field", 64'(cond_field), 0);
        check("R12 reset illegal", 64'(illegal), 0);

        // directed
        issue(mk(6'd22, X_MAXS, 5'd3, 5'd1, 5'd2, 1'b0), va, vb, 1'b0, "R4 maxs neg pair");
        issue(mk(6'd22, X_MAXS, 5'd3, 5'd1, 5'd2, 1'b1), 64'd1, mn, 1'b0, "R4 maxs sign");
        issue(mk(6'd22, X_MINS, 5'd7, 5'd1, 5'd2, 1'b1), va, vb, 1'b1, "R6 mins neg");
        issue(mk(6'd22, X_MINS, 5'd3, 5'd1, 5'd2, 1'b1), 64'd1, mn, 1'b0, "R6 mins sign");
        issue(mk(6'd22, X_MAXU, 5'd9, 5'd1, 5'd2, 1'b0), va, vb, 1'b0, "R5 maxu");
        issue(mk(6'd22, X_MAXU, 5'd9, 5'd1, 5'd2, 1'b1), 64'd1, mn, 1'b1, "R5 R8 maxu msb set");
        issue(mk(6'd22, X_MINU, 5'd3, 5'd1, 5'd2, 1'b1), 64'd1, mn, 1'b0, "R7 minu");
        issue(mk(6'd22, X_MINU, 5'd4, 5'd1, 5'd2, 1'b1), 64'd0, 64'd5, 1'b0, "R8 zero result");
        issue(mk(6'd22, X_MINS, 5'd4, 5'd1, 5'd2, 1'b0), mn, 64'd5, 1'b1, "R10 no record");
        issue(mk(6'd21, X_MAXS, 5'd8, 5'd1, 5'd2, 1'b1), 64'd9, 64'd3, 1'b1, "R1 bad primary");
        issue(mk(6'd22, 10'b0111001111, 5'd8, 5'd1, 5'd2, 1'b1), 64'd9, 64'd3, 1'b0, "R3 bad xo");
        issue(mk(6'd22, X_MAXS, 5'd31, 5'd30, 5'd17, 1'b1), 64'd9, 64'd9, 1'b1, "R2 R4 tie");

        // random
        for (int i = 0; i < 600; i++) begin
            logic [9:0]  xo;
            logic [5:0]  po;
            logic [63:0] a, b;
            int k = $urandom_range(0, 9);
            case (k % 4)
                0: xo = X_MAXS; 1: xo = X_MAXU; 2: xo = X_MINS; default: xo = X_MINU;
            endcase
            if (k == 9) xo = 10'($urandom);
            po = ($urandom_range(0, 15) == 0) ? 6'($urandom) : 6'd22;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            case ($urandom_range(0, 5))
                0: b = a;
                1: begin a[63] = 1'b0; b[63] = 1'b1; end
                2: a = 64'd0;
                default: ;
            endcase
            issue(mk(po, xo, 5'($urandom), 5'($urandom), 5'($urandom), 1'($urandom)),
                  a, b, 1'($urandom), "R3-R9 random");
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule